// File: doc/BRIEF.md
# Event derandomizer write controller

This block sits in front of the derandomizing buffer of a detector front end and decides, once per bunch crossing, what is kept for the link packer. Each crossing brings raw channel words, a per-channel hit mask, the 12-bit crossing identifier and the decoded fast commands (bunch veto, header-only, non-zero-suppression mode, front-end reset and synch). A crossing that carries real data becomes a full record: a 24-bit header plus a data word, written into the main buffer. A crossing with no hits, under veto or under header-only becomes a header with a zero size field. It goes into a small side queue instead, so it uses no space in the main buffer.

A one-bit tag queue remembers which path each record took. Records therefore leave toward the packer in the order their crossings arrived, across both paths. When the main buffer has no more than a programmable number of free entries, data-bearing events are cut down to headers with a truncated flag instead of being lost. A front-end reset or synch command empties everything at once. A sticky overflow flag shows that a record was dropped because its queue was full.

Top module: `evbuf_write_ctrl`

## Requirements
- R1: Every record header is 24 bits: crossing identifier in bits 23:12, status in bits 11:8, size in bits 7:0. Status bit 11 copies the bunch veto command, bit 10 the header-only command, bit 9 the non-zero-suppression command, and bit 8 is the truncated flag.
- R2: A crossing with bunch veto, with header-only, or outside non-zero-suppression mode with an all-zero hit mask writes nothing to the main buffer. It is forwarded as a header-only record (out_has_data 0) with size 0 and out_data 0.
- R3: In normal mode, a crossing with at least one hit becomes a full record (out_has_data 1). Its size is the number of set hit-mask bits, and its data word holds each hit channel's word with non-hit channels zeroed (channel i in bits i*CW+CW-1 : i*CW).
- R4: With non-zero-suppression mode and no veto or header-only, the size is NCH and the data word carries every channel unchanged, whatever the hit mask.
- R5: When the main buffer holds DEPTH minus cfg_free_thresh entries or more (free entries at most cfg_free_thresh, counted before this cycle's read), an event that would be a full record becomes a header-only record with size 0 and status bit 8 set. Full records resume as soon as the free count exceeds the threshold.
- R6: A front-end reset or synch command clears the main buffer, the side queue and the order queue in that cycle. The crossing presented in that cycle is discarded, and out_valid is 0 in the following cycle.
- R7: Records are presented on the output in crossing arrival order, whichever path each one took. A record is consumed on a rising edge with out_valid and out_ready both high and no flush.
- R8: If a record arrives while its queue (side queue of SIDE_DEPTH entries, or main buffer) is full, the record is dropped and overflow goes to 1. Overflow then stays 1 until rst_n is asserted, and a flush command does not clear it.
- R9: After reset, out_valid and overflow are 0.
- R10: Bunch veto and header-only take precedence over non-zero-suppression mode: such a crossing is a header-only record with size 0 even when the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_free_thresh | input | CNT_W | Free-entry threshold at which truncation starts |
| in_valid | input | 1 | A crossing is presented this cycle |
| in_bxid | input | 12 | Crossing identifier |
| in_ch_data | input | NCH*CW | Raw channel words |
| in_hit_mask | input | NCH | One bit per channel that has a hit |
| cmd_bx_veto | input | 1 | Bunch veto command |
| cmd_header_only | input | 1 | Header-only command |
| cmd_nzs | input | 1 | Non-zero-suppression mode command |
| cmd_fe_reset | input | 1 | Front-end reset, flushes all queues |
| cmd_synch | input | 1 | Synch command, flushes all queues |
| out_ready | input | 1 | Packer accepts the presented record |
| out_valid | output | 1 | A record is presented |
| out_has_data | output | 1 | Presented record is a full record |
| out_header | output | 24 | Presented record header |
| out_data | output | NCH*CW | Presented record data word (zero for header-only) |
| overflow | output | 1 | Sticky flag for a dropped record |

## Verification
Random crossings mix hit masks (including empty ones), veto, header-only and suppression-off modes against a packer that stalls at random. This separates the three record kinds and exercises path interleaving in the order queue. Directed runs fill the main buffer with the packer stalled to reach the truncation threshold, then release one entry to show that full records resume exactly one entry later. Bursts of empty crossings overfill the side queue to trip the sticky flag, and a flush after that shows the flag survives. A flushed crossing carrying an event shows that nothing from that cycle is kept.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
    localparam int BXID_W = 12;
    localparam int STAT_W = 4;
    localparam int SIZE_W = 8;
    localparam int HDR_W  = BXID_W + STAT_W + SIZE_W;

    // status field bit positions (within the 4-bit field)
    localparam int ST_TRUNC = 0;
    localparam int ST_NZS   = 1;
    localparam int ST_HONLY = 2;
    localparam int ST_VETO  = 3;

    typedef struct packed {
        logic [BXID_W-1:0] bxid;
        logic [STAT_W-1:0] status;
        logic [SIZE_W-1:0] size;
    } evhdr_t;
endpackage

// File: rtl/evbuf_fifo.sv
module evbuf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] DEPTH_L  = LVL_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wptr = ptr_inc(st_q.wptr);
            if (pop)  st_d.rptr = ptr_inc(st_q.rptr);
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[st_q.wptr] <= wdata;
    end

    assign rdata = mem_q[st_q.rptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == DEPTH_L);
    assign level = st_q.cnt;

    // the caller never writes a full queue (dropping is decided upstream)
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // reads only happen with a record present
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L);
    // a flush leaves the queue empty in the next cycle
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/evbuf_classify.sv
module evbuf_classify
    import evbuf_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CW    = 8,
    parameter int DEPTH = 16,
    localparam int DATA_W = NCH * CW,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              in_valid,
    input  logic              flush,
    input  logic [BXID_W-1:0] in_bxid,
    input  logic [DATA_W-1:0] in_ch_data,
    input  logic [NCH-1:0]    in_hit_mask,
    input  logic              cmd_bx_veto,
    input  logic              cmd_header_only,
    input  logic              cmd_nzs,
    input  logic [CNT_W-1:0]  main_level,
    input  logic [CNT_W-1:0]  free_thresh,
    output evhdr_t            hdr,
    output logic [DATA_W-1:0] data,
    output logic              to_main,
    output logic              to_side
);
    localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
    localparam logic [SIZE_W-1:0] NCH_S   = SIZE_W'(NCH);

    logic [SIZE_W-1:0] hit_cnt;
    logic [DATA_W-1:0] masked;
    logic [CNT_W-1:0]  free_slots;
    logic              skip, trunc, full_ev;

    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < NCH; i++) begin
            hit_cnt = hit_cnt + SIZE_W'(in_hit_mask[i]);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_mask
        assign masked[g*CW +: CW] = in_hit_mask[g] ? in_ch_data[g*CW +: CW] : '0;
    end

    always_comb begin
        free_slots = DEPTH_C - main_level;
        skip       = cmd_bx_veto || cmd_header_only || (!cmd_nzs && (hit_cnt == '0));
        trunc      = !skip && (free_slots <= free_thresh);
        full_ev    = !skip && !trunc;

        hdr.bxid             = in_bxid;
        hdr.status           = '0;
        hdr.status[ST_VETO]  = cmd_bx_veto;
        hdr.status[ST_HONLY] = cmd_header_only;
        hdr.status[ST_NZS]   = cmd_nzs;
        hdr.status[ST_TRUNC] = trunc;
        hdr.size             = '0;
        data                 = '0;
        if (full_ev) begin
            hdr.size = cmd_nzs ? NCH_S : hit_cnt;
            data     = cmd_nzs ? in_ch_data : masked;
        end

        to_main = in_valid && !flush && full_ev;
        to_side = in_valid && !flush && !full_ev;
    end
endmodule

// File: rtl/evbuf_write_ctrl.sv
module evbuf_write_ctrl
    import evbuf_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CW         = 8,
    parameter int DEPTH      = 16,
    parameter int SIDE_DEPTH = 4,
    localparam int DATA_W    = NCH * CW,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int ORD_DEPTH = DEPTH + SIDE_DEPTH,
    localparam int SIDE_LW   = $clog2(SIDE_DEPTH + 1),
    localparam int ORD_LW    = $clog2(ORD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_free_thresh,
    input  logic              in_valid,
    input  logic [11:0]       in_bxid,
    input  logic [DATA_W-1:0] in_ch_data,
    input  logic [NCH-1:0]    in_hit_mask,
    input  logic              cmd_bx_veto,
    input  logic              cmd_header_only,
    input  logic              cmd_nzs,
    input  logic              cmd_fe_reset,
    input  logic              cmd_synch,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_has_data,
    output logic [23:0]       out_header,
    output logic [DATA_W-1:0] out_data,
    output logic              overflow
);
    typedef struct packed {
        logic ovf;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic              flush;
    evhdr_t            cls_hdr;
    logic [DATA_W-1:0] cls_data;
    logic              to_main, to_side;

    logic                     main_push, main_pop, main_empty, main_full;
    logic [HDR_W+DATA_W-1:0]  main_rdata;
    logic [CNT_W-1:0]         main_level;
    logic                     side_push, side_pop, side_empty, side_full;
    logic [HDR_W-1:0]         side_rdata;
    logic [SIDE_LW-1:0]       side_level;
    logic                     ord_push, ord_pop, ord_empty, ord_full, ord_tag;
    logic [ORD_LW-1:0]        ord_level;
    logic                     accept;

    assign flush = cmd_fe_reset || cmd_synch;

    evbuf_classify #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH)) u_cls (
        .in_valid        (in_valid),
        .flush           (flush),
        .in_bxid         (in_bxid),
        .in_ch_data      (in_ch_data),
        .in_hit_mask     (in_hit_mask),
        .cmd_bx_veto     (cmd_bx_veto),
        .cmd_header_only (cmd_header_only),
        .cmd_nzs         (cmd_nzs),
        .main_level      (main_level),
        .free_thresh     (cfg_free_thresh),
        .hdr             (cls_hdr),
        .data            (cls_data),
        .to_main         (to_main),
        .to_side         (to_side)
    );

    assign main_push = to_main && !main_full;
    assign side_push = to_side && !side_full;
    assign ord_push  = main_push || side_push;

    assign accept   = !ord_empty && out_ready && !flush;
    assign main_pop = accept && ord_tag;
    assign side_pop = accept && !ord_tag;
    assign ord_pop  = accept;

    evbuf_fifo #(.WIDTH(HDR_W + DATA_W), .DEPTH(DEPTH)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (main_push),
        .wdata ({cls_hdr, cls_data}),
        .pop   (main_pop),
        .rdata (main_rdata),
        .empty (main_empty),
        .full  (main_full),
        .level (main_level)
    );

    evbuf_fifo #(.WIDTH(HDR_W), .DEPTH(SIDE_DEPTH)) u_side (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (side_push),
        .wdata (cls_hdr),
        .pop   (side_pop),
        .rdata (side_rdata),
        .empty (side_empty),
        .full  (side_full),
        .level (side_level)
    );

    // tag 1 = record waits in the main buffer, 0 = in the side queue
    evbuf_fifo #(.WIDTH(1), .DEPTH(ORD_DEPTH)) u_order (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (ord_push),
        .wdata (main_push),
        .pop   (ord_pop),
        .rdata (ord_tag),
        .empty (ord_empty),
        .full  (ord_full),
        .level (ord_level)
    );

    always_comb begin
        st_d = st_q;
        if ((to_main && main_full) || (to_side && side_full)) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        out_valid    = !ord_empty;
        out_has_data = !ord_empty && ord_tag;
        out_header   = '0;
        out_data     = '0;
        if (!ord_empty) begin
            if (ord_tag) begin
                out_header = main_rdata[HDR_W+DATA_W-1:DATA_W];
                out_data   = main_rdata[DATA_W-1:0];
            end else begin
                out_header = side_rdata;
            end
        end
    end

    assign overflow = st_q.ovf;

    // the tag queue and the two record queues stay consistent
    p_tag_main_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ord_tag) |-> !main_empty);
    p_tag_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ord_tag) |-> !side_empty);
    p_ord_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ord_level == ORD_LW'(main_level) + ORD_LW'(side_level));
    // header-only records carry no size and no data
    p_hdronly_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_has_data) |-> (out_header[7:0] == 8'd0 && out_data == '0));
    // full records have a non-zero size and no truncated flag
    p_full_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_data) |-> (out_header[7:0] != 8'd0 && !out_header[8]));
    // vetoed or header-only crossings never reach the main buffer
    p_veto_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cmd_bx_veto || cmd_header_only)) |-> !main_push);
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    p_ovf_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(main_full || side_full));
endmodule

// File: tb/evbuf_write_ctrl_tb.sv
module evbuf_write_ctrl_tb;
    localparam int NCH = 4, CW = 8, DEPTH = 16, SIDE = 4;
    localparam int DW = NCH * CW;

    typedef struct packed {
        logic          has;
        logic [23:0]   hdr;
        logic [DW-1:0] data;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n;
    logic [4:0] cfg_free_thresh;
    logic in_valid;
    logic [11:0] in_bxid;
    logic [DW-1:0] in_ch_data;
    logic [NCH-1:0] in_hit_mask;
    logic cmd_bx_veto, cmd_header_only, cmd_nzs, cmd_fe_reset, cmd_synch;
    logic out_ready, out_valid, out_has_data, overflow;
    logic [23:0] out_header;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    evbuf_write_ctrl #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH), .SIDE_DEPTH(SIDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_free_thresh(cfg_free_thresh),
        .in_valid(in_valid), .in_bxid(in_bxid), .in_ch_data(in_ch_data),
        .in_hit_mask(in_hit_mask), .cmd_bx_veto(cmd_bx_veto),
        .cmd_header_only(cmd_header_only), .cmd_nzs(cmd_nzs),
        .cmd_fe_reset(cmd_fe_reset), .cmd_synch(cmd_synch),
        .out_ready(out_ready), .out_valid(out_valid), .out_has_data(out_has_data),
        .out_header(out_header), .out_data(out_data), .overflow(overflow)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    rec_t exp_q[$];
    int   main_cnt = 0, side_cnt = 0;
    logic ovf_m = 1'b0;
    string phase = "R3";

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic rec_t model(input logic [11:0] bx, input logic [DW-1:0] d,
                                   input logic [NCH-1:0] m, input logic veto, ho, nzs,
                                   input int mcnt, input int thr);
        rec_t r;
        int cnt = 0;
        logic skip, trunc, fullv;
        logic [DW-1:0] md = '0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                cnt++;
                md[i*CW +: CW] = d[i*CW +: CW];
            end
        end
        skip  = veto || ho || (!nzs && cnt == 0);
        trunc = !skip && ((DEPTH - mcnt) <= thr);
        fullv = !skip && !trunc;
        r.has  = fullv;
        r.hdr  = {bx, veto, ho, nzs, trunc, fullv ? (nzs ? 8'(NCH) : 8'(cnt)) : 8'd0};
        r.data = fullv ? (nzs ? d : md) : '0;
        return r;
    endfunction

    function automatic string kind_tag(input rec_t r);
        if (r.has) return r.hdr[9] ? "R1 R4" : "R1 R3";
        if (r.hdr[8]) return "R1 R5";
        return "R1 R2";
    endfunction

    // one crossing: called at a falling edge, returns at the next falling edge
    task automatic step(input logic v, input logic [11:0] bx, input logic [DW-1:0] d,
                        input logic [NCH-1:0] m, input logic veto, ho, nzs, fer, syn, rdy);
        rec_t r, pr;
        bit   popped = 0;
        bit   fl = fer || syn;
        check(out_valid == (exp_q.size() != 0), {phase, " R7 valid"}, 64'(out_valid), 64'(exp_q.size() != 0));
        if (!fl && rdy && exp_q.size() != 0) begin
            pr = exp_q.pop_front();
            popped = 1;
            check(out_has_data == pr.has && out_header == pr.hdr && out_data == pr.data,
                  {phase, " R7 ", kind_tag(pr)},
                  {out_has_data, 7'd0, out_header, out_data}, {pr.has, 7'd0, pr.hdr, pr.data});
        end
        if (fl) begin
            exp_q.delete();
            main_cnt = 0;
            side_cnt = 0;
        end else begin
            if (v) begin
                r = model(bx, d, m, veto, ho, nzs, main_cnt, int'(cfg_free_thresh));
                if (r.has) begin
                    if (main_cnt < DEPTH) begin exp_q.push_back(r); main_cnt++; end
                    else ovf_m = 1'b1;
                end else begin
                    if (side_cnt < SIDE) begin exp_q.push_back(r); side_cnt++; end
                    else ovf_m = 1'b1;
                end
            end
            if (popped) begin
                if (pr.has) main_cnt--; else side_cnt--;
            end
        end
        in_valid = v; in_bxid = bx; in_ch_data = d; in_hit_mask = m;
        cmd_bx_veto = veto; cmd_header_only = ho; cmd_nzs = nzs;
        cmd_fe_reset = fer; cmd_synch = syn; out_ready = rdy;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic rdy);
        step(1'b0, 12'd0, '0, '0, 0, 0, 0, 0, 0, rdy);
    endtask

    task automatic drain();
        for (int k = 0; k < 40; k++) idle(1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] bx = 12'd1;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_free_thresh = 5'd2;
        in_valid = 0; in_bxid = 0; in_ch_data = 0; in_hit_mask = 0;
        cmd_bx_veto = 0; cmd_header_only = 0; cmd_nzs = 0;
        cmd_fe_reset = 0; cmd_synch = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
        check(overflow == 1'b0, "R9 overflow", 64'(overflow), 64'd0);

        // directed record kinds, packer ready
        phase = "R3";
        step(1, 12'h123, 32'hA1B2C3D4, 4'b0101, 0, 0, 0, 0, 0, 1);
        phase = "R4";
        step(1, 12'h124, 32'h11223344, 4'b0000, 0, 0, 1, 0, 0, 1);
        phase = "R2";
        step(1, 12'h125, 32'hFFFFFFFF, 4'b0000, 0, 0, 0, 0, 0, 1);
        step(1, 12'h126, 32'hFFFFFFFF, 4'b1111, 1, 0, 0, 0, 0, 1);
        step(1, 12'h127, 32'hFFFFFFFF, 4'b1111, 0, 1, 0, 0, 0, 1);
        phase = "R10";
        step(1, 12'h128, 32'h55667788, 4'b1111, 1, 0, 1, 0, 0, 1);
        step(1, 12'h129, 32'h55667788, 4'b0011, 0, 1, 1, 0, 0, 1);
        drain();

        // ordering across paths with a stalled packer
        phase = "R7";
        for (int k = 0; k < 8; k++)
            step(1, 12'h200 + 12'(k), 32'hC0DE0000 + 32'(k), 4'(k), 0, 0, 0, 0, 0, 0);
        drain();

        // truncation threshold
        phase = "R5";
        cfg_free_thresh = 5'd2;
        for (int k = 0; k < 15; k++)
            step(1, 12'h300 + 12'(k), 32'h01020304, 4'b1001, 0, 0, 0, 0, 0, 0);
        check(exp_q.size() == 15 && main_cnt == 14, "R5 model fill", 64'(main_cnt), 64'd14);
        step(1, 12'h310, 32'h0A0B0C0D, 4'b0001, 0, 0, 0, 0, 0, 1); // pops one, level 14 -> truncated
        step(1, 12'h311, 32'h0A0B0C0D, 4'b0001, 0, 0, 0, 0, 0, 0); // level 13 -> stored in full
        drain();

        // flush discards buffered records and the flush crossing
        phase = "R6";
        for (int k = 0; k < 5; k++)
            step(1, 12'h400 + 12'(k), 32'h99999999, 4'b0110, 0, 0, 0, 0, 0, 0);
        step(1, 12'h405, 32'h12345678, 4'b1111, 0, 0, 0, 1, 0, 1);
        check(out_valid == 1'b0, "R6 after fe reset", 64'(out_valid), 64'd0);
        step(1, 12'h406, 32'h12345678, 4'b1111, 0, 0, 0, 0, 0, 0);
        step(1, 12'h407, 32'h12345678, 4'b1111, 0, 0, 0, 0, 1, 0);
        check(out_valid == 1'b0, "R6 after synch", 64'(out_valid), 64'd0);
        drain();

        // side queue overflow, sticky through flush, cleared by reset
        phase = "R8";
        check(overflow == 1'b0, "R8 before", 64'(overflow), 64'd0);
        for (int k = 0; k < SIDE + 1; k++)
            step(1, 12'h500 + 12'(k), '0, '0, 0, 0, 0, 0, 0, 0);
        check(overflow == 1'b1, "R8 set", 64'(overflow), 64'd1);
        drain();
        step(0, 12'd0, '0, '0, 0, 0, 0, 1, 0, 0);
        check(overflow == 1'b1, "R8 kept after flush", 64'(overflow), 64'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete(); main_cnt = 0; side_cnt = 0; ovf_m = 1'b0;
        check(overflow == 1'b0, "R8 cleared by reset", 64'(overflow), 64'd0);

        // constrained random traffic
        phase = "RND R3";
        for (int seg = 0; seg < 4; seg++) begin
            cfg_free_thresh = 5'($urandom_range(0, 5));
            for (int k = 0; k < 1500; k++) begin
                logic v    = ($urandom_range(0, 9) < 8);
                logic veto = ($urandom_range(0, 9) == 0);
                logic ho   = ($urandom_range(0, 9) == 0);
                logic nzs  = ($urandom_range(0, 4) == 0);
                logic fer  = ($urandom_range(0, 199) == 0);
                logic syn  = ($urandom_range(0, 199) == 0);
                logic rdy  = ($urandom_range(0, 9) < (seg[0] ? 9 : 6));
                logic [NCH-1:0] m = ($urandom_range(0, 3) == 0) ? '0 : NCH'($urandom);
                step(v, bx, DW'($urandom), m, veto, ho, nzs, fer, syn, rdy);
                bx = bx + 12'd1;
            end
            check(overflow == ovf_m, "R8 random overflow", 64'(overflow), 64'(ovf_m));
        end
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule